// File: doc/BRIEF.md
# Oscillator divider bring-up sequencer

This block powers up a digitally controlled crystal oscillator by driving a byte-wide register-access master. After a start pulse it selects register page zero, turns off the calibration override, switches the oscillator output off, and then proves that the device is present. The presence test writes each scratch value in turn to a read/write register and reads it back. Once the device has answered correctly, the block loads the high-speed, low-speed and feedback dividers, starts the internal VCO calibration, waits for it to finish, turns the output back on, and waits for the frequency to settle before it reports completion.

Each register access is a single request that the block holds steady until the master returns a response. Every delay is a clock-cycle count set by a parameter, so a short count can stand in for the millisecond waits. While the sequence runs, the block raises a flag that claims the oscillator's bus. In the helper-oscillator variant it also holds a reset line high for the loop that the oscillator feeds. A detection mismatch or any error reported by the master ends the sequence at once and returns an error code.

Top module: `dcxo_seq`

## Requirements
- R1: After reset, busy, done, error, req_valid, owns_bus and helper_rst are all 0. A start pulse while idle makes busy 1 in the next cycle.
- R2: The first three requests are writes, in this order: register 255 with 0x00, register 69 with 0x00, register 17 with 0x00.
- R3: Next, for each value v from 0 up to 254 in ascending order, the block writes v to register 23 and then reads register 23 (req_write = 1 for writes, 0 for reads).
- R4: If a scratch read returns anything other than the value just written, the block pulses error in the cycle after the response and sets err_code to DET_CODE (all ones, 0xF by default). It issues no further request.
- R5: After the presence test, register 23 is written with hsdiv[7:0]. Register 24 is then written with lsdiv in bits [7:4], 0 in bit 3 and hsdiv[10:8] in bits [2:0].
- R6: Registers 26, 27, 28, 29, 30 and 31 are written with fbdiv bytes, least significant byte first (register 26 gets fbdiv[7:0], register 31 gets fbdiv[47:40]).
- R7: Register 7 is written with 0x08. The request that writes 0x01 to register 17 appears CAL_CYCLES+1 cycles after the cycle that carries the response to the register 7 write.
- R8: done pulses for exactly one cycle, SETTLE_CYCLES+1 cycles after the cycle that carries the response to the register 17 = 0x01 write. busy falls in that same cycle, and error stays 0 throughout a successful run.
- R9: owns_bus is 1 whenever busy is 1. With HELPER = 1, helper_rst is 1 for the whole run. Both are 0 once the run has ended, whether it succeeded or failed.
- R10: A response with rsp_err = 1 ends the run. In the next cycle error pulses, err_code equals the rsp_code that came with the response, and busy and owns_bus are 0. No further request follows.
- R11: A start pulse while busy is ignored. The run goes on with the same sequence of requests and produces a single done pulse.
- R12: While req_valid is 1 and no response has arrived, req_reg, req_wdata and req_write keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a bring-up run when idle |
| hsdiv | input | HS_W (11) | High-speed divider value |
| lsdiv | input | LS_W (4) | Low-speed divider value |
| fbdiv | input | FB_W (48) | Feedback divider value |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| error | output | 1 | One-cycle pulse when a run aborts |
| err_code | output | ERR_W (4) | Reason for the last abort; held until the next start |
| owns_bus | output | 1 | Claims the oscillator bus for this sequencer |
| helper_rst | output | 1 | Held reset for the loop fed by the helper oscillator |
| req_valid | output | 1 | A register access is requested |
| req_write | output | 1 | 1 = write, 0 = read |
| req_reg | output | 8 | Register number |
| req_wdata | output | 8 | Write data |
| rsp_valid | input | 1 | Master has finished the current access |
| rsp_rdata | input | 8 | Read data returned with the response |
| rsp_err | input | 1 | Master reports a failed access |
| rsp_code | input | ERR_W (4) | Master error code |

## Verification
The bench records each request in the cycle it first appears and each response in the cycle the model raises it. Every timed result is then checked as an exact cycle distance. The register 17 enable request must appear CAL_CYCLES+1 cycles after the calibration-start response. The done pulse must appear SETTLE_CYCLES+1 cycles after the enable response. An error pulse must appear one cycle after the failing response. All outputs are sampled on the falling edge, half a cycle after the registers that drive them have updated, so each check reads the value that the counted cycle produced. Request content is checked from the log, entry by entry, against a list that the bench computes from the divider inputs.

// File: rtl/dcxo_seq_pkg.sv
package dcxo_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_STEP,
      ST_SCR_WR,
      ST_SCR_RD,
      ST_CAL,
      ST_SETTLE
   } seq_state_e;

   localparam logic [7:0] RG_PAGE    = 8'd255;
   localparam logic [7:0] RG_CALOVR  = 8'd69;
   localparam logic [7:0] RG_OUTEN   = 8'd17;
   localparam logic [7:0] RG_SCRATCH = 8'd23;
   localparam logic [7:0] RG_DIVHI   = 8'd24;
   localparam logic [7:0] RG_FB0     = 8'd26;
   localparam logic [7:0] RG_CTRL    = 8'd7;

   localparam logic [7:0] CTRL_CAL_GO = 8'h08;
   localparam logic [7:0] OUTEN_ON    = 8'h01;

   typedef struct packed {
      logic [7:0] addr;
      logic [7:0] data;
   } reg_op_t;

endpackage

// File: rtl/dcxo_step_rom.sv
module dcxo_step_rom
   import dcxo_seq_pkg::*;
#(
   parameter int HS_W  = 11,
   parameter int LS_W  = 4,
   parameter int FB_W  = 48,
   parameter int IDX_W = 4
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [HS_W-1:0]  hsdiv,
   input  logic [LS_W-1:0]  lsdiv,
   input  logic [FB_W-1:0]  fbdiv,
   output reg_op_t          op
);

   localparam int FB_BYTES = FB_W / 8;
   localparam int IDX_HS   = 3;
   localparam int IDX_PK   = 4;
   localparam int IDX_FB   = 5;
   localparam int IDX_CAL  = IDX_FB + FB_BYTES;
   localparam int IDX_EN   = IDX_CAL + 1;

   logic [15:0] hs_ext;
   logic [3:0]  ls_ext;

   assign hs_ext = 16'(hsdiv);
   assign ls_ext = 4'(lsdiv);

   always_comb begin
      int k;
      int fb_sel;
      k      = int'(idx);
      fb_sel = 0;
      op     = '{addr: RG_PAGE, data: 8'h00};
      if (k == 1) begin
         op = '{addr: RG_CALOVR, data: 8'h00};
      end else if (k == 2) begin
         op = '{addr: RG_OUTEN, data: 8'h00};
      end else if (k == IDX_HS) begin
         op = '{addr: RG_SCRATCH, data: hs_ext[7:0]};
      end else if (k == IDX_PK) begin
         op = '{addr: RG_DIVHI, data: {ls_ext, hs_ext[11:8]}};
      end else if (k >= IDX_FB && k < IDX_CAL) begin
         fb_sel  = k - IDX_FB;
         op.addr = RG_FB0 + 8'(fb_sel);
         op.data = fbdiv[fb_sel*8 +: 8];
      end else if (k == IDX_CAL) begin
         op = '{addr: RG_CTRL, data: CTRL_CAL_GO};
      end else if (k == IDX_EN) begin
         op = '{addr: RG_OUTEN, data: OUTEN_ON};
      end
   end

endmodule

// File: rtl/dcxo_delay_timer.sv
module dcxo_delay_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] cycles,
   output logic          expired
);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= cycles - 1'b1;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/dcxo_seq.sv
module dcxo_seq
   import dcxo_seq_pkg::*;
#(
   parameter int                HS_W          = 11,
   parameter int                LS_W          = 4,
   parameter int                FB_W          = 48,
   parameter int                ERR_W         = 4,
   parameter logic [ERR_W-1:0]  DET_CODE      = '1,
   parameter int                SCRATCH_N     = 255,
   parameter int                CAL_CYCLES    = 1_500_000,
   parameter int                SETTLE_CYCLES = 2_000_000,
   parameter bit                HELPER        = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [HS_W-1:0]  hsdiv,
   input  logic [LS_W-1:0]  lsdiv,
   input  logic [FB_W-1:0]  fbdiv,
   output logic             busy,
   output logic             done,
   output logic             error,
   output logic [ERR_W-1:0] err_code,
   output logic             owns_bus,
   output logic             helper_rst,
   output logic             req_valid,
   output logic             req_write,
   output logic [7:0]       req_reg,
   output logic [7:0]       req_wdata,
   input  logic             rsp_valid,
   input  logic [7:0]       rsp_rdata,
   input  logic             rsp_err,
   input  logic [ERR_W-1:0] rsp_code
);

   localparam int FB_BYTES  = FB_W / 8;
   localparam int IDX_PRE   = 2;
   localparam int IDX_HS    = 3;
   localparam int IDX_CAL   = 5 + FB_BYTES;
   localparam int IDX_EN    = IDX_CAL + 1;
   localparam int IDX_W     = $clog2(IDX_EN + 1);
   localparam int MAX_WAIT  = (CAL_CYCLES > SETTLE_CYCLES) ? CAL_CYCLES : SETTLE_CYCLES;
   localparam int TW        = $clog2(MAX_WAIT + 1);

   if (HS_W <= 8 || HS_W > 12) begin : g_bad_hs
      $error("HS_W must lie in 9..12");
   end
   if (LS_W < 1 || LS_W > 4) begin : g_bad_ls
      $error("LS_W must lie in 1..4");
   end
   if (FB_W % 8 != 0 || FB_W < 8 || FB_W > 48) begin : g_bad_fb
      $error("FB_W must be a whole number of bytes, at most 6");
   end
   if (SCRATCH_N < 1 || SCRATCH_N > 256) begin : g_bad_scr
      $error("SCRATCH_N must lie in 1..256");
   end
   if (CAL_CYCLES < 1 || SETTLE_CYCLES < 1) begin : g_bad_wait
      $error("wait counts must be at least one cycle");
   end
   if (ERR_W < 1) begin : g_bad_err
      $error("ERR_W must be positive");
   end

   seq_state_e       st;
   logic [IDX_W-1:0] idx;
   logic [7:0]       scr;
   logic             owns_q;
   logic             done_q;
   logic             err_q;
   logic [ERR_W-1:0] code_q;
   reg_op_t          op;
   logic             tm_load;
   logic [TW-1:0]    tm_cycles;
   logic             tm_expired;
   logic             at_cal;
   logic             at_en;

   dcxo_step_rom #(
      .HS_W (HS_W),
      .LS_W (LS_W),
      .FB_W (FB_W),
      .IDX_W(IDX_W)
   ) u_rom (
      .idx  (idx),
      .hsdiv(hsdiv),
      .lsdiv(lsdiv),
      .fbdiv(fbdiv),
      .op   (op)
   );

   dcxo_delay_timer #(
      .TW(TW)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (tm_load),
      .cycles (tm_cycles),
      .expired(tm_expired)
   );

   assign at_cal    = (idx == IDX_W'(IDX_CAL));
   assign at_en     = (idx == IDX_W'(IDX_EN));
   assign tm_load   = (st == ST_STEP) && rsp_valid && !rsp_err && (at_cal || at_en);
   assign tm_cycles = at_cal ? TW'(CAL_CYCLES) : TW'(SETTLE_CYCLES);

   always_comb begin
      req_valid = 1'b0;
      req_write = 1'b1;
      req_reg   = op.addr;
      req_wdata = op.data;
      case (st)
         ST_STEP:   req_valid = 1'b1;
         ST_SCR_WR: begin
            req_valid = 1'b1;
            req_reg   = RG_SCRATCH;
            req_wdata = scr;
         end
         ST_SCR_RD: begin
            req_valid = 1'b1;
            req_write = 1'b0;
            req_reg   = RG_SCRATCH;
            req_wdata = 8'h00;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         idx    <= '0;
         scr    <= '0;
         owns_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         code_q <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  st     <= ST_STEP;
                  idx    <= '0;
                  owns_q <= 1'b1;
                  code_q <= '0;
               end
            end
            ST_STEP: begin
               if (rsp_valid) begin
                  if (rsp_err) begin
                     st     <= ST_IDLE;
                     owns_q <= 1'b0;
                     err_q  <= 1'b1;
                     code_q <= rsp_code;
                  end else if (idx == IDX_W'(IDX_PRE)) begin
                     st  <= ST_SCR_WR;
                     scr <= '0;
                  end else if (at_cal) begin
                     st <= ST_CAL;
                  end else if (at_en) begin
                     st <= ST_SETTLE;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            ST_SCR_WR: begin
               if (rsp_valid) begin
                  if (rsp_err) begin
                     st     <= ST_IDLE;
                     owns_q <= 1'b0;
                     err_q  <= 1'b1;
                     code_q <= rsp_code;
                  end else begin
                     st <= ST_SCR_RD;
                  end
               end
            end
            ST_SCR_RD: begin
               if (rsp_valid) begin
                  if (rsp_err) begin
                     st     <= ST_IDLE;
                     owns_q <= 1'b0;
                     err_q  <= 1'b1;
                     code_q <= rsp_code;
                  end else if (rsp_rdata != scr) begin
                     st     <= ST_IDLE;
                     owns_q <= 1'b0;
                     err_q  <= 1'b1;
                     code_q <= DET_CODE;
                  end else if (scr == 8'(SCRATCH_N - 1)) begin
                     st  <= ST_STEP;
                     idx <= IDX_W'(IDX_HS);
                  end else begin
                     scr <= scr + 8'd1;
                     st  <= ST_SCR_WR;
                  end
               end
            end
            ST_CAL: begin
               if (tm_expired) begin
                  st  <= ST_STEP;
                  idx <= IDX_W'(IDX_EN);
               end
            end
            ST_SETTLE: begin
               if (tm_expired) begin
                  st     <= ST_IDLE;
                  owns_q <= 1'b0;
                  done_q <= 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   if (HELPER) begin : g_helper
      assign helper_rst = owns_q;
   end else begin : g_main
      assign helper_rst = 1'b0;
   end

   assign busy     = (st != ST_IDLE);
   assign owns_bus = owns_q;
   assign done     = done_q;
   assign error    = err_q;
   assign err_code = code_q;

endmodule

// File: rtl/dcxo_seq_chk.sv
module dcxo_seq_chk #(
   parameter int ERR_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic             error,
   input logic [ERR_W-1:0] err_code,
   input logic             owns_bus,
   input logic             req_valid,
   input logic             req_write,
   input logic [7:0]       req_reg,
   input logic [7:0]       req_wdata,
   input logic             rsp_valid,
   input logic             rsp_err,
   input logic [ERR_W-1:0] rsp_code
);

   assert_start_takes_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !req_valid);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_not_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error));

   assert_owns_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> owns_bus);

   assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && rsp_valid && rsp_err) |=>
         (!busy && !owns_bus && error && err_code == $past(rsp_code)));

   assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !rsp_valid) |=>
         (req_valid && $stable(req_reg) && $stable(req_wdata) && $stable(req_write)));

endmodule

bind dcxo_seq dcxo_seq_chk #(.ERR_W(ERR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .error    (error),
   .err_code (err_code),
   .owns_bus (owns_bus),
   .req_valid(req_valid),
   .req_write(req_write),
   .req_reg  (req_reg),
   .req_wdata(req_wdata),
   .rsp_valid(rsp_valid),
   .rsp_err  (rsp_err),
   .rsp_code (rsp_code)
);

// File: tb/dcxo_seq_bench.sv
module dcxo_seq_bench;

   localparam int CAL    = 20;
   localparam int SETTLE = 30;
   localparam int LAT    = 1;
   localparam int NTX    = 523;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [10:0] hsdiv = '0;
   logic [3:0]  lsdiv = '0;
   logic [47:0] fbdiv = '0;
   logic        busy, done, error, owns_bus, helper_rst;
   logic [3:0]  err_code;
   logic        req_valid, req_write;
   logic [7:0]  req_reg, req_wdata;
   logic        rsp_valid = 1'b0;
   logic [7:0]  rsp_rdata = '0;
   logic        rsp_err = 1'b0;
   logic [3:0]  rsp_code = '0;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   logic [7:0] mem [256];
   logic [7:0] log_reg [1024];
   logic [7:0] log_dat [1024];
   logic       log_wr  [1024];
   int         req_cyc [1024];
   int         rsp_cyc [1024];
   int ntx = 0;
   int seen = 0;
   int wait_n = 0;
   int fail_idx = -1;
   logic [3:0] fail_code = 4'h3;
   int corrupt_v = -1;
   int done_cnt = 0, done_cyc = 0;
   int err_cnt = 0, err_cyc = 0;
   logic [3:0] err_seen = '0;
   int own_bad = 0;

   dcxo_seq #(
      .CAL_CYCLES   (CAL),
      .SETTLE_CYCLES(SETTLE),
      .HELPER       (1'b1)
   ) u_dcxo_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .hsdiv(hsdiv), .lsdiv(lsdiv), .fbdiv(fbdiv),
      .busy(busy), .done(done), .error(error), .err_code(err_code),
      .owns_bus(owns_bus), .helper_rst(helper_rst),
      .req_valid(req_valid), .req_write(req_write),
      .req_reg(req_reg), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .rsp_err(rsp_err), .rsp_code(rsp_code)
   );

   always #10 clk = ~clk;

   always @(posedge clk) cyc++;

   // register-access master model, acting on the falling edge
   always @(negedge clk) begin
      if (rsp_valid) begin
         rsp_valid = 1'b0;
         rsp_err   = 1'b0;
      end else if (rst_n && req_valid) begin
         if (seen == 0) begin
            req_cyc[ntx] = cyc;
            seen   = 1;
            wait_n = 0;
         end
         if (wait_n < LAT) begin
            wait_n++;
         end else begin
            log_reg[ntx] = req_reg;
            log_dat[ntx] = req_wdata;
            log_wr[ntx]  = req_write;
            rsp_cyc[ntx] = cyc;
            rsp_valid    = 1'b1;
            if (ntx == fail_idx) begin
               rsp_err  = 1'b1;
               rsp_code = fail_code;
            end else if (req_write) begin
               mem[req_reg] = req_wdata;
            end else begin
               rsp_rdata = mem[req_reg];
               if (corrupt_v >= 0 && mem[req_reg] == 8'(corrupt_v))
                  rsp_rdata = mem[req_reg] ^ 8'h01;
            end
            ntx++;
            seen = 0;
         end
      end
      if (done) begin
         done_cnt++;
         done_cyc = cyc;
      end
      if (error) begin
         err_cnt++;
         err_cyc  = cyc;
         err_seen = err_code;
      end
      if (busy && (!owns_bus || !helper_rst)) own_bad++;
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_reg(input int i);
      if (i == 0) return 8'd255;
      if (i == 1) return 8'd69;
      if (i == 2) return 8'd17;
      if (i < 513) return 8'd23;
      if (i == 513) return 8'd23;
      if (i == 514) return 8'd24;
      if (i < 521) return 8'(26 + i - 515);
      if (i == 521) return 8'd7;
      return 8'd17;
   endfunction

   function automatic logic [7:0] exp_dat(input int i);
      logic [15:0] h;
      h = 16'(hsdiv);
      if (i < 3) return 8'h00;
      if (i < 513) return 8'((i - 3) / 2);
      if (i == 513) return h[7:0];
      if (i == 514) return {lsdiv, 1'b0, h[10:8]};
      if (i < 521) return fbdiv[(i-515)*8 +: 8];
      if (i == 521) return 8'h08;
      return 8'h01;
   endfunction

   function automatic bit exp_wr(input int i);
      if (i >= 3 && i < 513) return ((i - 3) % 2) == 0;
      return 1'b1;
   endfunction

   task automatic kick();
      ntx = 0;
      own_bad = 0;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_end();
      int d0, e0;
      d0 = done_cnt;
      e0 = err_cnt;
      while (done_cnt == d0 && err_cnt == e0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk(!busy && !done && !error, "R1 idle outputs", {busy, done, error}, 0);
      chk(!req_valid && !owns_bus && !helper_rst, "R1 bus idle", {req_valid, owns_bus, helper_rst}, 0);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy, "R1 start takes next cycle", busy, 1);
      wait_end();
   endtask

   task automatic check_log(input string tag);
      int nb;
      nb = 0;
      for (int i = 0; i < NTX; i++) begin
         if (log_reg[i] != exp_reg(i) || log_wr[i] != exp_wr(i) ||
             (exp_wr(i) && log_dat[i] != exp_dat(i))) begin
            if (nb == 0) begin
               bad++;
               $display("FAIL %s at request %0d actual=%0h/%0h/%0b expected=%0h/%0h/%0b",
                        tag, i, log_reg[i], log_dat[i], log_wr[i],
                        exp_reg(i), exp_dat(i), exp_wr(i));
            end
            nb++;
         end
      end
      total++;
   endtask

   task automatic t_full(input logic [10:0] h, input logic [3:0] l, input logic [47:0] f);
      int d0;
      hsdiv = h; lsdiv = l; fbdiv = f;
      d0 = done_cnt;
      kick();
      wait_end();
      chk(ntx == NTX, "R3 request count", ntx, NTX);
      chk(log_reg[0] == 8'd255 && log_reg[1] == 8'd69 && log_reg[2] == 8'd17 &&
          log_dat[2] == 8'h00, "R2 opening writes",
          {log_reg[0], log_reg[1], log_reg[2]}, 64'hFF4511);
      check_log("R3 R5 R6 request sequence");
      chk(log_reg[514] == 8'd24 && log_dat[514] == {l, 1'b0, h[10:8]}, "R5 packed divider",
          log_dat[514], {l, 1'b0, h[10:8]});
      chk(log_reg[520] == 8'd31 && log_dat[520] == f[47:40], "R6 top feedback byte",
          log_dat[520], f[47:40]);
      chk(req_cyc[522] - rsp_cyc[521] == CAL + 1, "R7 calibration wait",
          req_cyc[522] - rsp_cyc[521], CAL + 1);
      chk(done_cnt == d0 + 1 && done_cyc - rsp_cyc[522] == SETTLE + 1, "R8 settle wait",
          done_cyc - rsp_cyc[522], SETTLE + 1);
      chk(!busy && !done && !error, "R8 single done pulse, no error", {busy, done, error}, 0);
      chk(own_bad == 0 && !owns_bus && !helper_rst, "R9 ownership and helper reset",
          own_bad, 0);
   endtask

   task automatic t_restart_ignored();
      int d0;
      hsdiv = 11'h2A5; lsdiv = 4'h9; fbdiv = 48'h0123_4567_89AB;
      d0 = done_cnt;
      kick();
      while (ntx < 50) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_end();
      chk(ntx == NTX && done_cnt == d0 + 1, "R11 start while busy ignored", ntx, NTX);
      check_log("R11 sequence unchanged");
   endtask

   task automatic t_mismatch();
      int e0;
      corrupt_v = 100;
      e0 = err_cnt;
      kick();
      wait_end();
      chk(err_cnt == e0 + 1 && err_seen == 4'hF, "R4 detection error code", err_seen, 4'hF);
      chk(err_cyc - rsp_cyc[204] == 1, "R4 error one cycle after read", err_cyc - rsp_cyc[204], 1);
      repeat (10) @(negedge clk);
      chk(ntx == 205 && !req_valid && !busy, "R4 no request after mismatch", ntx, 205);
      chk(!owns_bus && !helper_rst, "R9 released after failure", {owns_bus, helper_rst}, 0);
      corrupt_v = -1;
   endtask

   task automatic t_master_err();
      int e0;
      fail_idx = 5;
      fail_code = 4'h3;
      e0 = err_cnt;
      kick();
      wait_end();
      chk(err_cnt == e0 + 1 && err_seen == 4'h3, "R10 passed code", err_seen, 4'h3);
      chk(err_cyc - rsp_cyc[5] == 1, "R10 abort timing", err_cyc - rsp_cyc[5], 1);
      repeat (10) @(negedge clk);
      chk(ntx == 6 && !req_valid && !busy && !owns_bus, "R10 stops at once", ntx, 6);
      fail_idx = -1;
   endtask

   task automatic t_hold();
      int bad_hold;
      logic [16:0] prev;
      bad_hold = 0;
      hsdiv = 11'h7FF; lsdiv = 4'hF; fbdiv = 48'hFFFF_FFFF_FFFF;
      ntx = 0;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      prev = {req_write, req_reg, req_wdata};
      while (busy) begin
         @(negedge clk);
         if (req_valid && !rsp_valid && seen == 1 && wait_n > 0 &&
             {req_write, req_reg, req_wdata} != prev) bad_hold++;
         prev = {req_write, req_reg, req_wdata};
      end
      @(negedge clk);
      chk(bad_hold == 0, "R12 request held until response", bad_hold, 0);
      check_log("R5 R6 all-ones dividers");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full(11'h4C3, 4'h5, 48'hA1B2_C3D4_E5F6);
      t_full(11'h001, 4'h0, 48'h0000_0000_0080);
      t_restart_ignored();
      t_mismatch();
      t_master_err();
      t_full(11'h6A9, 4'hC, 48'h1122_3344_5566);
      t_hold();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      while (cyc < 150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule